// File: doc/BRIEF.md
# SDRAM Single-Access and Refresh Sequencer

This block sits between a simple system bus and one SDRAM device. It accepts single-word read and write requests and turns each one into the matching SDRAM command sequence on the command, bank and address pins. A request is marked by an active-low address strobe and a read/write select, and it carries a flat word address and write data. The block splits the address into bank, row and column fields and opens the row with ACTIVE. It then issues READ or WRITE with address bit 10 set, so the device precharges the row on its own. After that it waits out the CAS latency or the write recovery time. Read data goes back to the bus together with a one-cycle valid flag.

A free-running interval counter raises a refresh request every `REF_PERIOD` cycles. The request stays set until the sequencer acknowledges it. When the sequencer is idle, a pending refresh is served before any bus request. The acknowledge stays high for the whole refresh and the bus strobe is ignored during that time. Every wait state is timed by one shared cycle counter. The counter is cleared whenever the sequencer changes state and counts up while it stays in a state. Device power-up initialisation is handled elsewhere and is reported to this block by `init_done`.

Top module: `sdram_seq`

## Requirements
- R1: While `init_done` is low, the sequencer stays idle. Only NOP (cs_n,ras_n,cas_n,we_n = 0111) appears on the command pins, `ref_ack` stays low and the strobe has no effect. After reset, `rd_valid`, `ref_req`, `ref_ack` and `sd_dq_oe` are all low.
- R2: In idle, with `init_done` high, a pending `ref_req` wins over an asserted strobe. The next cycle carries REFRESH (0001), not ACTIVE.
- R3: The flat address is split as {bank[1:0], row[12:0], col[8:0]}, with the bank in the most significant bits. The cycle after a strobe is accepted carries ACTIVE (0011) with the bank on `sd_ba` and the row on `sd_a`.
- R4: READ (0101) and WRITE (0100) carry the column on `sd_a[8:0]`, the same bank on `sd_ba`, and `sd_a[10]` = 1. `sd_cke` is always high.
- R5: The READ or WRITE command follows ACTIVE by exactly `T_RCD` cycles, with NOPs in between. When `T_RCD` is 1, the command comes in the very next cycle.
- R6: `bus_rd` is sampled in the cycle just before the command. A value of 1 selects READ and a value of 0 selects WRITE.
- R7: `rd_valid` is high for exactly one cycle, `CAS_LAT` cycles after the READ command. In that cycle `rd_data` equals `sd_dq_in`.
- R8: `sd_dq_oe` is high only in the WRITE command cycle, with `sd_dq_out` holding the write data. The sequencer is idle again 2+`T_WR` cycles after WRITE and can accept a new strobe in that cycle.
- R9: `ref_req` rises every `REF_PERIOD` cycles and stays high until `ref_ack` is seen.
- R10: A refresh is one REFRESH command followed by NOPs. `ref_ack` is high for exactly `T_RFC` cycles, the strobe is ignored during that time, and the sequencer is then idle.
- R11: A read from an address returns the data last written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_done | input | 1 | Device initialisation finished |
| bus_strobe_n | input | 1 | Active-low request strobe |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 24 | Flat word address |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data to the bus |
| rd_valid | output | 1 | Read data valid |
| ref_req | output | 1 | Sticky refresh request |
| ref_ack | output | 1 | Refresh in progress |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 13 | Row / column address |
| sd_dq_out | output | 32 | Data toward the device |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 32 | Data from the device |

## Verification
The assertions assume a bus that holds `bus_rd` steady from the strobe until the command cycle. They also assume that `init_done` never drops once it is set. The bench respects both rules. It starts a request only on a cycle where the block is idle and both `ref_req` and `ref_ack` are low, except in the one test that holds the strobe low on purpose during a refresh. It models the device as an array that captures the open row on ACTIVE, stores on WRITE, and returns read data `CAS_LAT` edges after READ. Requests sweep all banks with corner rows and columns.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE     = 4'b0000,
      ST_ACT      = 4'b0001,
      ST_ACT_DLY  = 4'b0010,
      ST_WR       = 4'b0101,
      ST_WR_DATA  = 4'b0110,
      ST_WR_REC   = 4'b0111,
      ST_RD       = 4'b1000,
      ST_CAS_WAIT = 4'b1001,
      ST_RD_OUT   = 4'b1010,
      ST_AREF     = 4'b1100,
      ST_RFC_WAIT = 4'b1101
   } seq_state_t;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } sd_cmd_t;

   localparam sd_cmd_t CMD_NOP     = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
   localparam sd_cmd_t CMD_ACTIVE  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
   localparam sd_cmd_t CMD_READ    = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
   localparam sd_cmd_t CMD_WRITE   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};
   localparam sd_cmd_t CMD_REFRESH = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

endpackage

// File: rtl/sdram_seq_timer.sv
module sdram_seq_timer #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else          cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/sdram_seq_refresh.sv
module sdram_seq_refresh #(
   parameter int REF_PERIOD = 780
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_ack,
   output logic ref_req
);

   localparam int RW = (REF_PERIOD > 2) ? $clog2(REF_PERIOD) : 1;
   localparam logic [RW-1:0] LAST = RW'(REF_PERIOD - 1);

   logic [RW-1:0] ivl_cnt;
   logic          tick;

   assign tick = (ivl_cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ivl_cnt <= '0;
         ref_req <= 1'b0;
      end else begin
         ivl_cnt <= tick ? '0 : ivl_cnt + 1'b1;
         if (tick)         ref_req <= 1'b1;
         else if (ref_ack) ref_req <= 1'b0;
      end
   end

   p_req_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_req && !ref_ack) |=> ref_req);

endmodule

// File: rtl/sdram_seq_fsm.sv
module sdram_seq_fsm
   import sdram_seq_pkg::*;
#(
   parameter int T_RCD   = 2,
   parameter int CAS_LAT = 2,
   parameter int T_WR    = 2,
   parameter int T_RFC   = 4,
   parameter int CNT_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_done,
   input  logic             strobe_n,
   input  logic             bus_rd,
   input  logic             ref_req,
   input  logic [CNT_W-1:0] tcnt,
   output seq_state_t       state,
   output logic             tclr,
   output logic             accept
);

   localparam logic [CNT_W-1:0] LAST_RCD = CNT_W'((T_RCD > 1) ? T_RCD - 2 : 0);
   localparam logic [CNT_W-1:0] LAST_CAS = CNT_W'(CAS_LAT - 2);
   localparam logic [CNT_W-1:0] LAST_WR  = CNT_W'(T_WR - 1);
   localparam logic [CNT_W-1:0] LAST_RFC = CNT_W'(T_RFC - 2);

   seq_state_t nxt;
   seq_state_t act_nxt;
   seq_state_t cmd_pick;

   assign cmd_pick = bus_rd ? ST_RD : ST_WR;

   generate
      if (T_RCD > 1) begin : g_act_wait
         assign act_nxt = ST_ACT_DLY;
      end else begin : g_act_direct
         assign act_nxt = cmd_pick;
      end
   endgenerate

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE: begin
            if (init_done) begin
               if (ref_req)        nxt = ST_AREF;
               else if (!strobe_n) nxt = ST_ACT;
            end
         end
         ST_ACT:      nxt = act_nxt;
         ST_ACT_DLY:  if (tcnt == LAST_RCD) nxt = cmd_pick;
         ST_RD:       nxt = ST_CAS_WAIT;
         ST_CAS_WAIT: if (tcnt == LAST_CAS) nxt = ST_RD_OUT;
         ST_RD_OUT:   nxt = ST_IDLE;
         ST_WR:       nxt = ST_WR_DATA;
         ST_WR_DATA:  nxt = ST_WR_REC;
         ST_WR_REC:   if (tcnt == LAST_WR) nxt = ST_IDLE;
         ST_AREF:     nxt = ST_RFC_WAIT;
         ST_RFC_WAIT: if (tcnt == LAST_RFC) nxt = ST_IDLE;
         default:     nxt = ST_IDLE;
      endcase
   end

   assign tclr   = (nxt != state);
   assign accept = (state == ST_IDLE) && init_done && !ref_req && !strobe_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   p_init_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !init_done) |=> state == ST_IDLE);

   p_refresh_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && init_done && ref_req) |=> state == ST_AREF);

   p_active_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACT) |=> (state != ST_ACT && state != ST_IDLE));

   p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RD_OUT) |=> state == ST_IDLE);

endmodule

// File: rtl/sdram_seq_cmd.sv
module sdram_seq_cmd
   import sdram_seq_pkg::*;
#(
   parameter int BANK_W = 2,
   parameter int ROW_W  = 13,
   parameter int COL_W  = 9,
   parameter int DATA_W = 32,
   parameter int AP_BIT = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  seq_state_t        state,
   input  logic [BANK_W-1:0] bank,
   input  logic [ROW_W-1:0]  row,
   input  logic [COL_W-1:0]  col,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] dq_in,
   output sd_cmd_t           cmd,
   output logic [BANK_W-1:0] ba,
   output logic [ROW_W-1:0]  a,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);

   logic [ROW_W-1:0] col_addr;

   always_comb begin
      col_addr             = '0;
      col_addr[COL_W-1:0]  = col;
      col_addr[AP_BIT]     = 1'b1;
   end

   always_comb begin
      cmd = CMD_NOP;
      a   = '0;
      case (state)
         ST_ACT:  begin cmd = CMD_ACTIVE;  a = row;      end
         ST_RD:   begin cmd = CMD_READ;    a = col_addr; end
         ST_WR:   begin cmd = CMD_WRITE;   a = col_addr; end
         ST_AREF: begin cmd = CMD_REFRESH;               end
         default: ;
      endcase
   end

   assign ba       = bank;
   assign dq_out   = wdata;
   assign dq_oe    = (state == ST_WR);
   assign rd_data  = dq_in;
   assign rd_valid = (state == ST_RD_OUT);

   p_autoprecharge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd.cs_n && cmd.ras_n && !cmd.cas_n) |-> a[AP_BIT]);

   p_oe_only_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> (cmd == CMD_WRITE));

endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
   import sdram_seq_pkg::*;
#(
   parameter int BANK_W     = 2,
   parameter int ROW_W      = 13,
   parameter int COL_W      = 9,
   parameter int DATA_W     = 32,
   parameter int T_RCD      = 2,
   parameter int CAS_LAT    = 2,
   parameter int T_WR       = 2,
   parameter int T_RFC      = 4,
   parameter int REF_PERIOD = 780,
   localparam int ADDR_W    = BANK_W + ROW_W + COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_done,
   input  logic              bus_strobe_n,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              ref_req,
   output logic              ref_ack,
   output logic              sd_cke,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [BANK_W-1:0] sd_ba,
   output logic [ROW_W-1:0]  sd_a,
   output logic [DATA_W-1:0] sd_dq_out,
   output logic              sd_dq_oe,
   input  logic [DATA_W-1:0] sd_dq_in
);

   localparam int AP_BIT = 10;
   localparam int MAX_A  = (T_RCD > CAS_LAT) ? T_RCD : CAS_LAT;
   localparam int MAX_B  = (T_WR > T_RFC) ? T_WR : T_RFC;
   localparam int MAX_D  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CNT_W  = $clog2(MAX_D + 1);

   generate
      if (ROW_W <= AP_BIT || COL_W > AP_BIT) begin : g_bad_addr
         $fatal(1, "sdram_seq: row must cover bit 10 and column must fit below it");
      end
      if (T_RCD < 1 || CAS_LAT < 2 || T_WR < 1 || T_RFC < 2 || REF_PERIOD < 2) begin : g_bad_timing
         $fatal(1, "sdram_seq: timing parameter out of range");
      end
   endgenerate

   seq_state_t        state;
   logic              tclr;
   logic              accept;
   logic [CNT_W-1:0]  tcnt;
   sd_cmd_t           cmd;
   logic [BANK_W-1:0] bank_q;
   logic [ROW_W-1:0]  row_q;
   logic [COL_W-1:0]  col_q;
   logic [DATA_W-1:0] wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q  <= '0;
         row_q   <= '0;
         col_q   <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         {bank_q, row_q, col_q} <= bus_addr;
         wdata_q                <= bus_wdata;
      end
   end

   assign ref_ack = (state == ST_AREF) || (state == ST_RFC_WAIT);

   sdram_seq_timer #(.CNT_W(CNT_W)) u_timer (
      .clk (clk), .rst_n (rst_n), .clr (tclr), .cnt (tcnt)
   );

   sdram_seq_refresh #(.REF_PERIOD(REF_PERIOD)) u_refresh (
      .clk (clk), .rst_n (rst_n), .ref_ack (ref_ack), .ref_req (ref_req)
   );

   sdram_seq_fsm #(
      .T_RCD (T_RCD), .CAS_LAT (CAS_LAT), .T_WR (T_WR), .T_RFC (T_RFC), .CNT_W (CNT_W)
   ) u_fsm (
      .clk (clk), .rst_n (rst_n), .init_done (init_done), .strobe_n (bus_strobe_n),
      .bus_rd (bus_rd), .ref_req (ref_req), .tcnt (tcnt),
      .state (state), .tclr (tclr), .accept (accept)
   );

   sdram_seq_cmd #(
      .BANK_W (BANK_W), .ROW_W (ROW_W), .COL_W (COL_W), .DATA_W (DATA_W), .AP_BIT (AP_BIT)
   ) u_cmd (
      .clk (clk), .rst_n (rst_n), .state (state),
      .bank (bank_q), .row (row_q), .col (col_q), .wdata (wdata_q), .dq_in (sd_dq_in),
      .cmd (cmd), .ba (sd_ba), .a (sd_a), .dq_out (sd_dq_out), .dq_oe (sd_dq_oe),
      .rd_data (rd_data), .rd_valid (rd_valid)
   );

   assign sd_cke   = 1'b1;
   assign sd_cs_n  = cmd.cs_n;
   assign sd_ras_n = cmd.ras_n;
   assign sd_cas_n = cmd.cas_n;
   assign sd_we_n  = cmd.we_n;

   p_ack_opens_with_refresh_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ref_ack) |-> (cmd == CMD_REFRESH));

endmodule

// File: tb/sdram_seq_tb.sv
module sdram_seq_tb;

   localparam int CLK_PERIOD = 10;
   localparam int T_RCD      = 2;
   localparam int CAS_LAT    = 2;
   localparam int T_WR       = 2;
   localparam int T_RFC      = 4;
   localparam int REF_P      = 100;

   localparam logic [3:0] C_NOP = 4'b0111;
   localparam logic [3:0] C_ACT = 4'b0011;
   localparam logic [3:0] C_RD  = 4'b0101;
   localparam logic [3:0] C_WR  = 4'b0100;
   localparam logic [3:0] C_REF = 4'b0001;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        init_done;
   logic        bus_strobe_n;
   logic        bus_rd;
   logic [23:0] bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] rd_data;
   logic        rd_valid, ref_req, ref_ack;
   logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [1:0]  sd_ba;
   logic [12:0] sd_a;
   logic [31:0] sd_dq_out;
   logic        sd_dq_oe;
   logic [31:0] sd_dq_in;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdram_seq #(
      .T_RCD (T_RCD), .CAS_LAT (CAS_LAT), .T_WR (T_WR), .T_RFC (T_RFC), .REF_PERIOD (REF_P)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .init_done (init_done), .bus_strobe_n (bus_strobe_n),
      .bus_rd (bus_rd), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
      .rd_data (rd_data), .rd_valid (rd_valid), .ref_req (ref_req), .ref_ack (ref_ack),
      .sd_cke (sd_cke), .sd_cs_n (sd_cs_n), .sd_ras_n (sd_ras_n), .sd_cas_n (sd_cas_n),
      .sd_we_n (sd_we_n), .sd_ba (sd_ba), .sd_a (sd_a), .sd_dq_out (sd_dq_out),
      .sd_dq_oe (sd_dq_oe), .sd_dq_in (sd_dq_in)
   );

   // behavioural device model
   logic [12:0] open_row [4];
   logic [31:0] dev_mem [logic [23:0]];
   logic [31:0] rpipe [CAS_LAT];
   logic [31:0] rd_word;

   function automatic logic [3:0] cmd_now();
      return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
   endfunction

   always @(posedge clk) begin
      rd_word = 32'hDEAD_BEEF;
      if (cmd_now() == C_ACT) open_row[sd_ba] = sd_a;
      if (cmd_now() == C_WR) dev_mem[{sd_ba, open_row[sd_ba], sd_a[8:0]}] = sd_dq_out;
      if (cmd_now() == C_RD && dev_mem.exists({sd_ba, open_row[sd_ba], sd_a[8:0]}))
         rd_word = dev_mem[{sd_ba, open_row[sd_ba], sd_a[8:0]}];
      rpipe[0] <= rd_word;
      for (int k = 1; k < CAS_LAT; k++) rpipe[k] <= rpipe[k-1];
   end
   assign sd_dq_in = rpipe[CAS_LAT-1];

   // expected contents kept by the bench
   logic [31:0] ref_mem [logic [23:0]];

   function automatic logic [31:0] pat(logic [23:0] ad, int salt);
      return ({8'h0, ad} * 32'h9E37_79B1) ^ (32'h0102_0304 * salt);
   endfunction

   task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // body of one access, entered at the negedge of the ACTIVE cycle
   task automatic op_body(bit rd, logic [23:0] ad, logic [31:0] d);
      bus_strobe_n = 1'b1;
      chk(cmd_now() == C_ACT, "R3 active", 64'(cmd_now()), 64'(C_ACT));
      chk(sd_ba == ad[23:22], "R3 bank", 64'(sd_ba), 64'(ad[23:22]));
      chk(sd_a == ad[21:9], "R3 row", 64'(sd_a), 64'(ad[21:9]));
      for (int i = 2; i <= T_RCD; i++) begin
         @(negedge clk);
         chk(cmd_now() == C_NOP, "R5 gap", 64'(cmd_now()), 64'(C_NOP));
      end
      @(negedge clk);
      chk(cmd_now() == (rd ? C_RD : C_WR), "R6 cmd", 64'(cmd_now()), 64'(rd ? C_RD : C_WR));
      chk(sd_a[10] == 1'b1, "R4 a10", 64'(sd_a[10]), 64'd1);
      chk(sd_a[8:0] == ad[8:0] && sd_ba == ad[23:22], "R4 col",
          64'({sd_ba, sd_a[8:0]}), 64'({ad[23:22], ad[8:0]}));
      chk(sd_dq_oe == !rd, "R8 oe", 64'(sd_dq_oe), 64'(!rd));
      if (!rd) chk(sd_dq_out == d, "R8 wdata", 64'(sd_dq_out), 64'(d));
      bus_rd = 1'b0;
      if (rd) begin
         for (int i = 1; i < CAS_LAT; i++) begin
            @(negedge clk);
            chk(rd_valid == 1'b0, "R7 early", 64'(rd_valid), 64'd0);
         end
         @(negedge clk);
         chk(rd_valid == 1'b1, "R7 valid", 64'(rd_valid), 64'd1);
         chk(rd_data == d, "R11 readback", 64'(rd_data), 64'(d));
         @(negedge clk);
         chk(rd_valid == 1'b0, "R7 single", 64'(rd_valid), 64'd0);
      end else begin
         ref_mem[ad] = d;
         for (int i = 0; i <= T_WR; i++) begin
            @(negedge clk);
            chk(sd_dq_oe == 1'b0 && cmd_now() == C_NOP, "R8 recovery",
                64'({sd_dq_oe, cmd_now()}), 64'({1'b0, C_NOP}));
         end
         @(negedge clk);
         chk(cmd_now() == C_NOP, "R8 idle", 64'(cmd_now()), 64'(C_NOP));
      end
   endtask

   // starts at a negedge with the sequencer idle, ends at an idle negedge
   task automatic op(bit rd, logic [23:0] ad, logic [31:0] d);
      while (ref_req || ref_ack) @(negedge clk);
      bus_strobe_n = 1'b0;
      bus_rd       = rd;
      bus_addr     = ad;
      bus_wdata    = d;
      @(negedge clk);
      op_body(rd, ad, d);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [23:0] addrs [36];
      int na;
      int t_rise;
      logic [23:0] ax;
      rst_n = 1'b0; init_done = 1'b0; bus_strobe_n = 1'b1; bus_rd = 1'b0;
      bus_addr = '0; bus_wdata = '0;
      repeat (3) @(negedge clk);
      chk({rd_valid, ref_req, ref_ack, sd_dq_oe} == 4'b0, "R1 reset",
          64'({rd_valid, ref_req, ref_ack, sd_dq_oe}), 64'd0);
      chk(cmd_now() == C_NOP && sd_cke, "R1 reset cmd", 64'({sd_cke, cmd_now()}), 64'({1'b1, C_NOP}));
      rst_n = 1'b1;
      bus_strobe_n = 1'b0;
      for (int i = 0; i < 150; i++) begin
         @(negedge clk);
         chk(cmd_now() == C_NOP && !ref_ack, "R1 no cmd before init",
             64'({ref_ack, cmd_now()}), 64'({1'b0, C_NOP}));
      end
      chk(ref_req == 1'b1, "R9 held", 64'(ref_req), 64'd1);
      bus_strobe_n = 1'b1;
      init_done = 1'b1;
      @(negedge clk);
      chk(cmd_now() == C_REF && ref_ack, "R10 refresh cmd", 64'({ref_ack, cmd_now()}), 64'({1'b1, C_REF}));
      while (ref_ack) @(negedge clk);

      // R9 interval
      while (!ref_req) @(negedge clk);
      while (ref_req || ref_ack) @(negedge clk);
      t_rise = 0;
      while (!ref_req) begin @(negedge clk); t_rise++; end
      while (ref_req || ref_ack) @(negedge clk);
      t_rise = 0;
      while (!ref_req) begin @(negedge clk); t_rise++; end
      // t_rise counts idle cycles after refresh; add refresh duration plus the idle cycle
      chk(t_rise + T_RFC + 1 == REF_P, "R9 period", 64'(t_rise + T_RFC + 1), 64'(REF_P));

      // R2 / R10 with strobe held low while refresh is pending
      ax = {2'd2, 13'h0ABC, 9'h055};
      bus_strobe_n = 1'b0; bus_rd = 1'b0; bus_addr = ax; bus_wdata = pat(ax, 9);
      @(negedge clk);
      chk(cmd_now() == C_REF, "R2 refresh first", 64'(cmd_now()), 64'(C_REF));
      chk(ref_ack == 1'b1, "R10 ack", 64'(ref_ack), 64'd1);
      for (int i = 2; i <= T_RFC; i++) begin
         @(negedge clk);
         chk(cmd_now() == C_NOP && ref_ack && !ref_req, "R10 busy",
             64'({ref_req, ref_ack, cmd_now()}), 64'({2'b01, C_NOP}));
      end
      @(negedge clk);
      chk(cmd_now() == C_NOP && !ref_ack, "R10 done", 64'({ref_ack, cmd_now()}), 64'({1'b0, C_NOP}));
      @(negedge clk);
      op_body(1'b0, ax, pat(ax, 9));
      op(1'b1, ax, pat(ax, 9));

      // sweep banks, corner rows and columns
      na = 0;
      for (int b = 0; b < 4; b++)
         for (int r = 0; r < 3; r++)
            for (int c = 0; c < 3; c++) begin
               addrs[na] = {2'(b), (r == 0) ? 13'h0000 : (r == 1) ? 13'h1FFF : 13'h0A5A,
                            (c == 0) ? 9'h000 : (c == 1) ? 9'h1FF : 9'h0B3};
               na++;
            end
      foreach (addrs[i]) op(1'b0, addrs[i], pat(addrs[i], 1));
      foreach (addrs[i]) op(1'b1, addrs[i], ref_mem[addrs[i]]);
      for (int i = 0; i < 36; i += 5) begin
         op(1'b0, addrs[i], pat(addrs[i], 7));
         op(1'b1, addrs[i], pat(addrs[i], 7));
         op(1'b1, addrs[35 - i], ref_mem[addrs[35 - i]]);
      end

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule